// File: doc/BRIEF.md
# Byte-Lane Dual-Port RAM

This block is a synchronous memory with two independent access ports, left and right. The memory holds 2048 words of 16 bits. Each port has an 11-bit address, an active-low select, an active-low read enable and one active-low write strobe per byte lane. The per-lane strobes let one port write one byte of a word and read the other byte of that word in the same access. Read data is registered, so it appears one clock after the access. Each lane carries a valid flag that takes the place of a tri-state driver.

Each port also has an active-low busy line. While busy is low, every write on that port is cancelled, but its reads go on as normal. A mode parameter decides where busy comes from. In master mode it comes from an on-chip collision detector: when both ports are selected at the same address, the lower-priority port is made busy. In slave mode it comes from a pin per port, so that a second device can follow the busy decision of a master and the two can form a wider word. When one port writes a word that the other port reads in the same cycle, the reader gets the new bytes.

Top module: `dpram_bytelane`

## Requirements
- R1: The store holds 2048 words of 16 bits, selected by an 11-bit address on each port, with no aliasing between addresses 0 and 2047. Both ports may read the same word in the same cycle and both get its contents.
- R2: When a port's select is high, that port writes nothing. Both of its valid flags are 0 on the cycle after, whatever its other controls are.
- R3: With the select low and busy high, each lane whose write strobe is low takes the port's write data for that lane at the clock edge. Lane 0 is bits 7:0 with strobe bit 0, and lane 1 is bits 15:8 with strobe bit 1.
- R4: With the select low, a lane whose strobe is high and whose read enable is low gives the stored byte and valid flag 1 one clock later. Valid bit 0 belongs to lane 0. If the read enable is high, both valid flags are 0.
- R5: A single access may write one lane and read the other. The lane being written shows valid 0, and the other lane returns its stored byte.
- R6: While a port's busy is low, none of its lanes is written. Its reads return data exactly as they would without busy.
- R7: In slave mode, each port's busy comes from its busy input, and the busy output copies that input.
- R8: In master mode, the busy inputs are ignored. When both ports are selected at the same address, the lower-priority port's busy goes low in the same cycle and the other port's busy stays high. The right port is the lower-priority port by default. In all other cases both busy lines stay high, and the two are never low together.
- R9: If one port writes a lane of a word without being busy, and the other port reads that lane of the same word in the same cycle, the reader gets the newly written byte on the next cycle.
- R10: A lane whose valid flag is 0 reads as zero. Reset clears all read data and all valid flags.
- R11: If both ports write the same lane of the same word in the same cycle and neither is busy, the left port's data is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the read registers |
| l_addr | input | 11 | Left word address |
| l_sel_n | input | 1 | Left select, active low |
| l_ren_n | input | 1 | Left read enable, active low |
| l_wen_n | input | 2 | Left lane write strobes, active low; bit 0 is the low byte |
| l_wdata | input | 16 | Left write data |
| l_busy_in_n | input | 1 | Left busy input, used in slave mode |
| l_busy_n | output | 1 | Left busy in effect, active low |
| l_rdata | output | 16 | Left registered read data |
| l_rvalid | output | 2 | Left per-lane read valid |
| r_addr | input | 11 | Right word address |
| r_sel_n | input | 1 | Right select, active low |
| r_ren_n | input | 1 | Right read enable, active low |
| r_wen_n | input | 2 | Right lane write strobes, active low; bit 0 is the low byte |
| r_wdata | input | 16 | Right write data |
| r_busy_in_n | input | 1 | Right busy input, used in slave mode |
| r_busy_n | output | 1 | Right busy in effect, active low |
| r_rdata | output | 16 | Right registered read data |
| r_rvalid | output | 2 | Right per-lane read valid |

## Verification
The bench drives a master instance and a slave instance from the same stimulus, so a port collision shows up as two different results. It checks the following cases:

- **Collision in master mode.** A design that lets the losing port write, or that stalls its read, returns the wrong word afterwards.
- **Same-cycle write and read of one word.** A design without forwarding returns the old bytes.
- **Mixed access that writes one lane and reads the other.** A decoder that swaps lanes, or that marks the written lane valid, shows a wrong valid pattern or a wrong byte.
- **Busy input held low.** A slave that ignores busy, or a master that obeys it, leaves the wrong byte in the store.
- **Both ports writing the same word.** A design that keeps the right port's data fails the left-priority check.
- **Addresses 0 and 2047.** An address decode that is too narrow aliases the two words.

// File: rtl/dpbl_pkg.sv
package dpbl_pkg;
   typedef enum logic {
      BUSY_FROM_PIN     = 1'b0,
      BUSY_FROM_ARBITER = 1'b1
   } busy_mode_e;
endpackage

// File: rtl/dpbl_lane_dec.sv
module dpbl_lane_dec #(
   parameter int LANES = 2
) (
   input  logic             sel_n,
   input  logic             ren_n,
   input  logic [LANES-1:0] wen_n,
   input  logic             busy_n,
   output logic [LANES-1:0] wr_en,
   output logic [LANES-1:0] rd_en
);
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      always_comb begin
         wr_en[g] = !sel_n && !wen_n[g] && busy_n;
         rd_en[g] = !sel_n && wen_n[g] && !ren_n;
      end
   end
endmodule

// File: rtl/dpbl_busy_gen.sv
module dpbl_busy_gen
   import dpbl_pkg::*;
#(
   parameter busy_mode_e MODE      = BUSY_FROM_ARBITER,
   parameter int         AW        = 11,
   parameter bit         PRIO_LEFT = 1'b1
) (
   input  logic          l_sel_n,
   input  logic          r_sel_n,
   input  logic [AW-1:0] l_addr,
   input  logic [AW-1:0] r_addr,
   input  logic          l_busy_in_n,
   input  logic          r_busy_in_n,
   output logic          l_busy_n,
   output logic          r_busy_n
);
   if (MODE == BUSY_FROM_ARBITER) begin : g_master
      logic hit;
      logic unused_pins;
      always_comb begin
         hit         = !l_sel_n && !r_sel_n && (l_addr == r_addr);
         l_busy_n    = !(hit && !PRIO_LEFT);
         r_busy_n    = !(hit && PRIO_LEFT);
         unused_pins = l_busy_in_n ^ r_busy_in_n;
      end
   end else begin : g_slave
      logic unused_bits;
      always_comb begin
         l_busy_n    = l_busy_in_n;
         r_busy_n    = r_busy_in_n;
         unused_bits = (^l_addr) ^ (^r_addr) ^ l_sel_n ^ r_sel_n;
      end
   end
endmodule

// File: rtl/dpbl_array.sv
module dpbl_array #(
   parameter int AW     = 11,
   parameter int LANES  = 2,
   parameter int LANE_W = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [AW-1:0]           l_addr,
   input  logic [AW-1:0]           r_addr,
   input  logic [LANES*LANE_W-1:0] l_wdata,
   input  logic [LANES*LANE_W-1:0] r_wdata,
   input  logic [LANES-1:0]        l_wr,
   input  logic [LANES-1:0]        r_wr,
   input  logic [LANES-1:0]        l_rd,
   input  logic [LANES-1:0]        r_rd,
   output logic [LANES*LANE_W-1:0] l_rdata,
   output logic [LANES-1:0]        l_rvalid,
   output logic [LANES*LANE_W-1:0] r_rdata,
   output logic [LANES-1:0]        r_rvalid
);
   localparam int DEPTH = 1 << AW;

   logic same_addr;
   assign same_addr = (l_addr == r_addr);

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] mem [DEPTH];
      logic [LANE_W-1:0] l_wbyte, r_wbyte;
      logic [LANE_W-1:0] l_next, r_next;
      logic [LANE_W-1:0] l_q, r_q;
      logic              l_v, r_v;

      assign l_wbyte = l_wdata[g*LANE_W +: LANE_W];
      assign r_wbyte = r_wdata[g*LANE_W +: LANE_W];

      // right first so that the left port wins a same-word write
      always_ff @(posedge clk) begin
         if (r_wr[g]) mem[r_addr] <= r_wbyte;
         if (l_wr[g]) mem[l_addr] <= l_wbyte;
      end

      always_comb begin
         l_next = '0;
         r_next = '0;
         if (l_rd[g]) l_next = (r_wr[g] && same_addr) ? r_wbyte : mem[l_addr];
         if (r_rd[g]) r_next = (l_wr[g] && same_addr) ? l_wbyte : mem[r_addr];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            l_q <= '0;
            r_q <= '0;
            l_v <= 1'b0;
            r_v <= 1'b0;
         end else begin
            l_q <= l_next;
            r_q <= r_next;
            l_v <= l_rd[g];
            r_v <= r_rd[g];
         end
      end

      assign l_rdata[g*LANE_W +: LANE_W] = l_q;
      assign r_rdata[g*LANE_W +: LANE_W] = r_q;
      assign l_rvalid[g]                 = l_v;
      assign r_rvalid[g]                 = r_v;
   end
endmodule

// File: rtl/dpram_bytelane.sv
module dpram_bytelane
   import dpbl_pkg::*;
#(
   parameter int         AW        = 11,
   parameter int         LANES     = 2,
   parameter int         LANE_W    = 8,
   parameter busy_mode_e MODE      = BUSY_FROM_ARBITER,
   parameter bit         PRIO_LEFT = 1'b1,
   localparam int        DW        = LANES * LANE_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [AW-1:0]    l_addr,
   input  logic             l_sel_n,
   input  logic             l_ren_n,
   input  logic [LANES-1:0] l_wen_n,
   input  logic [DW-1:0]    l_wdata,
   input  logic             l_busy_in_n,
   output logic             l_busy_n,
   output logic [DW-1:0]    l_rdata,
   output logic [LANES-1:0] l_rvalid,
   input  logic [AW-1:0]    r_addr,
   input  logic             r_sel_n,
   input  logic             r_ren_n,
   input  logic [LANES-1:0] r_wen_n,
   input  logic [DW-1:0]    r_wdata,
   input  logic             r_busy_in_n,
   output logic             r_busy_n,
   output logic [DW-1:0]    r_rdata,
   output logic [LANES-1:0] r_rvalid
);
   if (AW < 1 || AW > 16) begin : g_bad_aw
      $error("dpram_bytelane: AW out of range");
   end
   if (LANES < 1) begin : g_bad_lanes
      $error("dpram_bytelane: LANES must be at least 1");
   end
   if (LANE_W < 1) begin : g_bad_lane_w
      $error("dpram_bytelane: LANE_W must be at least 1");
   end

   logic [LANES-1:0] l_wr, l_rd, r_wr, r_rd;

   dpbl_busy_gen #(.MODE(MODE), .AW(AW), .PRIO_LEFT(PRIO_LEFT)) busy_i (
      .l_sel_n    (l_sel_n),
      .r_sel_n    (r_sel_n),
      .l_addr     (l_addr),
      .r_addr     (r_addr),
      .l_busy_in_n(l_busy_in_n),
      .r_busy_in_n(r_busy_in_n),
      .l_busy_n   (l_busy_n),
      .r_busy_n   (r_busy_n)
   );

   dpbl_lane_dec #(.LANES(LANES)) ldec_i (
      .sel_n (l_sel_n),
      .ren_n (l_ren_n),
      .wen_n (l_wen_n),
      .busy_n(l_busy_n),
      .wr_en (l_wr),
      .rd_en (l_rd)
   );

   dpbl_lane_dec #(.LANES(LANES)) rdec_i (
      .sel_n (r_sel_n),
      .ren_n (r_ren_n),
      .wen_n (r_wen_n),
      .busy_n(r_busy_n),
      .wr_en (r_wr),
      .rd_en (r_rd)
   );

   dpbl_array #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) array_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .l_addr  (l_addr),
      .r_addr  (r_addr),
      .l_wdata (l_wdata),
      .r_wdata (r_wdata),
      .l_wr    (l_wr),
      .r_wr    (r_wr),
      .l_rd    (l_rd),
      .r_rd    (r_rd),
      .l_rdata (l_rdata),
      .l_rvalid(l_rvalid),
      .r_rdata (r_rdata),
      .r_rvalid(r_rvalid)
   );
endmodule

// File: rtl/dpbl_chk.sv
module dpbl_chk
   import dpbl_pkg::*;
#(
   parameter int         AW     = 11,
   parameter int         LANES  = 2,
   parameter int         LANE_W = 8,
   parameter busy_mode_e MODE   = BUSY_FROM_ARBITER
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic [AW-1:0]           l_addr,
   input logic                    l_sel_n,
   input logic                    l_ren_n,
   input logic [LANES-1:0]        l_wen_n,
   input logic [LANES*LANE_W-1:0] l_wdata,
   input logic                    l_busy_in_n,
   input logic                    l_busy_n,
   input logic [LANES*LANE_W-1:0] l_rdata,
   input logic [LANES-1:0]        l_rvalid,
   input logic [AW-1:0]           r_addr,
   input logic                    r_sel_n,
   input logic                    r_ren_n,
   input logic [LANES-1:0]        r_wen_n,
   input logic [LANES*LANE_W-1:0] r_wdata,
   input logic                    r_busy_in_n,
   input logic                    r_busy_n,
   input logic [LANES*LANE_W-1:0] r_rdata,
   input logic [LANES-1:0]        r_rvalid
);
   AST_DESEL_QUIET_L: assert property (@(posedge clk) disable iff (!rst_n) $past(l_sel_n) |-> (l_rvalid == '0)); // R2
   AST_DESEL_QUIET_R: assert property (@(posedge clk) disable iff (!rst_n) $past(r_sel_n) |-> (r_rvalid == '0)); // R2
   AST_REN_OFF_L: assert property (@(posedge clk) disable iff (!rst_n) $past(!l_sel_n && l_ren_n) |-> (l_rvalid == '0)); // R4
   AST_REN_OFF_R: assert property (@(posedge clk) disable iff (!rst_n) $past(!r_sel_n && r_ren_n) |-> (r_rvalid == '0)); // R4

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      AST_WLANE_UNDRIVEN_L: assert property (@(posedge clk) disable iff (!rst_n) $past(!l_wen_n[g]) |-> !l_rvalid[g]); // R5
      AST_WLANE_UNDRIVEN_R: assert property (@(posedge clk) disable iff (!rst_n) $past(!r_wen_n[g]) |-> !r_rvalid[g]); // R5
      AST_IDLE_ZERO_L: assert property (@(posedge clk) disable iff (!rst_n) !l_rvalid[g] |-> (l_rdata[g*LANE_W +: LANE_W] == '0)); // R10
      AST_IDLE_ZERO_R: assert property (@(posedge clk) disable iff (!rst_n) !r_rvalid[g] |-> (r_rdata[g*LANE_W +: LANE_W] == '0)); // R10
      AST_FWD_R_TO_L: assert property (@(posedge clk) disable iff (!rst_n)
         $past(!l_sel_n && !r_sel_n && (l_addr == r_addr) && !r_wen_n[g] && r_busy_n && l_wen_n[g] && !l_ren_n)
         |-> (l_rdata[g*LANE_W +: LANE_W] == $past(r_wdata[g*LANE_W +: LANE_W]))); // R9
      AST_FWD_L_TO_R: assert property (@(posedge clk) disable iff (!rst_n)
         $past(!l_sel_n && !r_sel_n && (l_addr == r_addr) && !l_wen_n[g] && l_busy_n && r_wen_n[g] && !r_ren_n)
         |-> (r_rdata[g*LANE_W +: LANE_W] == $past(l_wdata[g*LANE_W +: LANE_W]))); // R9
   end

   if (MODE == BUSY_FROM_ARBITER) begin : g_master
      AST_BUSY_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) !(!l_busy_n && !r_busy_n)); // R8
      AST_BUSY_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
         (l_sel_n || r_sel_n || (l_addr != r_addr)) |-> (l_busy_n && r_busy_n)); // R8
   end else begin : g_slave
      AST_BUSY_FOLLOWS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
         (l_busy_n == l_busy_in_n) && (r_busy_n == r_busy_in_n)); // R7
   end
endmodule

bind dpram_bytelane dpbl_chk #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W), .MODE(MODE)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .l_addr     (l_addr),
   .l_sel_n    (l_sel_n),
   .l_ren_n    (l_ren_n),
   .l_wen_n    (l_wen_n),
   .l_wdata    (l_wdata),
   .l_busy_in_n(l_busy_in_n),
   .l_busy_n   (l_busy_n),
   .l_rdata    (l_rdata),
   .l_rvalid   (l_rvalid),
   .r_addr     (r_addr),
   .r_sel_n    (r_sel_n),
   .r_ren_n    (r_ren_n),
   .r_wen_n    (r_wen_n),
   .r_wdata    (r_wdata),
   .r_busy_in_n(r_busy_in_n),
   .r_busy_n   (r_busy_n),
   .r_rdata    (r_rdata),
   .r_rvalid   (r_rvalid)
);

// File: tb/dpram_bytelane_tb_top.sv
module dpram_bytelane_tb_top;
   import dpbl_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [10:0] l_addr = '0, r_addr = '0;
   logic        l_sel_n = 1'b1, r_sel_n = 1'b1;
   logic        l_ren_n = 1'b1, r_ren_n = 1'b1;
   logic [1:0]  l_wen_n = 2'b11, r_wen_n = 2'b11;
   logic [15:0] l_wdata = '0, r_wdata = '0;
   logic        l_bin_n = 1'b1, r_bin_n = 1'b1;

   logic        m_lb, m_rb, s_lb, s_rb;
   logic [15:0] m_ld, m_rd, s_ld, s_rd;
   logic [1:0]  m_lv, m_rv, s_lv, s_rv;

   int total = 0;
   int bad   = 0;

   always #5 clk = ~clk;

   dpram_bytelane #(.MODE(BUSY_FROM_ARBITER)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .l_addr(l_addr), .l_sel_n(l_sel_n), .l_ren_n(l_ren_n), .l_wen_n(l_wen_n),
      .l_wdata(l_wdata), .l_busy_in_n(l_bin_n), .l_busy_n(m_lb), .l_rdata(m_ld), .l_rvalid(m_lv),
      .r_addr(r_addr), .r_sel_n(r_sel_n), .r_ren_n(r_ren_n), .r_wen_n(r_wen_n),
      .r_wdata(r_wdata), .r_busy_in_n(r_bin_n), .r_busy_n(m_rb), .r_rdata(m_rd), .r_rvalid(m_rv)
   );

   dpram_bytelane #(.MODE(BUSY_FROM_PIN)) dut_slv_i (
      .clk(clk), .rst_n(rst_n),
      .l_addr(l_addr), .l_sel_n(l_sel_n), .l_ren_n(l_ren_n), .l_wen_n(l_wen_n),
      .l_wdata(l_wdata), .l_busy_in_n(l_bin_n), .l_busy_n(s_lb), .l_rdata(s_ld), .l_rvalid(s_lv),
      .r_addr(r_addr), .r_sel_n(r_sel_n), .r_ren_n(r_ren_n), .r_wen_n(r_wen_n),
      .r_wdata(r_wdata), .r_busy_in_n(r_bin_n), .r_busy_n(s_rb), .r_rdata(s_rd), .r_rvalid(s_rv)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic idle();
      l_sel_n = 1'b1; r_sel_n = 1'b1;
      l_ren_n = 1'b1; r_ren_n = 1'b1;
      l_wen_n = 2'b11; r_wen_n = 2'b11;
      l_bin_n = 1'b1; r_bin_n = 1'b1;
   endtask

   task automatic lacc(input logic [10:0] a, input logic ren, input logic [1:0] wen, input logic [15:0] d);
      l_addr = a; l_sel_n = 1'b0; l_ren_n = ren; l_wen_n = wen; l_wdata = d;
   endtask

   task automatic racc(input logic [10:0] a, input logic ren, input logic [1:0] wen, input logic [15:0] d);
      r_addr = a; r_sel_n = 1'b0; r_ren_n = ren; r_wen_n = wen; r_wdata = d;
   endtask

   task automatic t_reset();
      check("R10 reset master left",  {m_lv, m_ld, m_rv[0]}, '0);
      check("R10 reset master right", {m_rv, m_rd}, '0);
      check("R10 reset slave",        {s_lv, s_ld, s_rv, s_rd}, '0);
   endtask

   task automatic t_write_read();
      idle(); lacc(11'd5, 1'b1, 2'b00, 16'h0123); step();
      idle(); lacc(11'd5, 1'b0, 2'b11, 16'h0); racc(11'd5, 1'b0, 2'b11, 16'h0); step();
      check("R3 R4 master left read",  {m_lv, m_ld}, {2'b11, 16'h0123});
      check("R1 master right same word", {m_rv, m_rd}, {2'b11, 16'h0123});
      check("R1 slave both ports", {s_lv, s_ld, s_rv, s_rd}, {2'b11, 16'h0123, 2'b11, 16'h0123});
      idle(); racc(11'd2047, 1'b1, 2'b00, 16'hBEEF); step();
      idle(); lacc(11'd0, 1'b1, 2'b00, 16'h0F0F); step();
      idle(); lacc(11'd2047, 1'b0, 2'b11, 16'h0); racc(11'd0, 1'b0, 2'b11, 16'h0); step();
      check("R1 top address",  {m_lv, m_ld}, {2'b11, 16'hBEEF});
      check("R1 address zero", {m_rv, m_rd}, {2'b11, 16'h0F0F});
   endtask

   task automatic t_deselect();
      idle(); l_addr = 11'd5; l_sel_n = 1'b1; l_ren_n = 1'b0; l_wen_n = 2'b00; l_wdata = 16'hFFFF; step();
      check("R2 deselect no valid", {m_lv, s_lv, m_ld}, '0);
      idle(); lacc(11'd5, 1'b0, 2'b11, 16'h0); step();
      check("R2 deselect no write", {m_lv, m_ld}, {2'b11, 16'h0123});
      idle(); lacc(11'd5, 1'b1, 2'b11, 16'h0); step();
      check("R4 read enable high", {m_lv, m_ld}, '0);
   endtask

   task automatic t_mixed();
      idle(); lacc(11'd5, 1'b0, 2'b10, 16'h77AA); step();
      check("R5 write low read high", {m_lv, m_ld}, {2'b10, 16'h0100});
      idle(); lacc(11'd5, 1'b0, 2'b11, 16'h0); step();
      check("R3 low lane only", {m_lv, m_ld}, {2'b11, 16'h01AA});
      idle(); lacc(11'd5, 1'b0, 2'b01, 16'h5566); step();
      check("R5 write high read low", {m_lv, m_ld}, {2'b01, 16'h00AA});
      idle(); lacc(11'd5, 1'b1, 2'b01, 16'h9900); step();
      check("R4 high write read off", {m_lv, m_ld}, '0);
      idle(); lacc(11'd5, 1'b0, 2'b11, 16'h0); step();
      check("R3 high lane only", {m_lv, m_ld}, {2'b11, 16'h99AA});
   endtask

   task automatic t_busy_pin();
      idle(); lacc(11'd9, 1'b1, 2'b00, 16'h2222); step();
      idle(); lacc(11'd9, 1'b0, 2'b10, 16'h1111); l_bin_n = 1'b0; #1;
      check("R7 slave busy copies pin", {s_lb, s_rb}, 2'b01);
      check("R8 master ignores pin", {m_lb, m_rb}, 2'b11);
      step();
      check("R6 read under busy slave", {s_lv, s_ld}, {2'b10, 16'h2200});
      check("R6 read master", {m_lv, m_ld}, {2'b10, 16'h2200});
      idle(); lacc(11'd9, 1'b0, 2'b11, 16'h0); step();
      check("R6 slave write cancelled", s_ld, 16'h2222);
      check("R8 master wrote low lane", m_ld, 16'h2211);
   endtask

   task automatic t_collide();
      idle(); lacc(11'd12, 1'b1, 2'b00, 16'h4444); step();
      idle(); lacc(11'd12, 1'b0, 2'b11, 16'h0); racc(11'd12, 1'b1, 2'b00, 16'h3333); #1;
      check("R8 right loses", {m_lb, m_rb}, 2'b10);
      check("R7 slave no busy", {s_lb, s_rb}, 2'b11);
      step();
      check("R8 master old data", {m_lv, m_ld}, {2'b11, 16'h4444});
      check("R9 slave forward", {s_lv, s_ld}, {2'b11, 16'h3333});
      idle(); lacc(11'd12, 1'b0, 2'b11, 16'h0); step();
      check("R8 master right write cancelled", m_ld, 16'h4444);
      check("R9 slave stored", s_ld, 16'h3333);
      idle(); lacc(11'd12, 1'b1, 2'b00, 16'h5A5A); racc(11'd12, 1'b0, 2'b11, 16'h0); #1;
      check("R8 right busy again", {m_lb, m_rb}, 2'b10);
      step();
      check("R9 R6 master forward to busy reader", {m_rv, m_rd}, {2'b11, 16'h5A5A});
      check("R9 slave forward to right", {s_rv, s_rd}, {2'b11, 16'h5A5A});
      idle(); lacc(11'd13, 1'b0, 2'b11, 16'h0); racc(11'd14, 1'b0, 2'b11, 16'h0); #1;
      check("R8 different addresses", {m_lb, m_rb}, 2'b11);
      step();
   endtask

   task automatic t_dual_write();
      idle(); lacc(11'd20, 1'b1, 2'b00, 16'hAAAA); racc(11'd20, 1'b1, 2'b00, 16'hBBBB); step();
      idle(); racc(11'd20, 1'b0, 2'b11, 16'h0); step();
      check("R11 slave left kept", s_rd, 16'hAAAA);
      check("R11 master left kept", m_rd, 16'hAAAA);
   endtask

   initial begin
      #200000;
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      t_reset();
      rst_n = 1'b1;
      step();
      t_write_read();
      t_deselect();
      t_mixed();
      t_busy_pin();
      t_collide();
      t_dual_write();
      idle();
      step();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule